// File: doc/BRIEF.md
# Host Receive Mailbox Queue

This block is a small first-in-first-out store. Peripheral channels post 32-bit messages into it, and a host CPU collects them through a word-wide register window. A producer offers a message with `push_valid`/`push_data`. The message is taken on a clock edge when the queue has room, and `push_ready` shows that room exists.

On the host side, a read of the pop window removes the oldest message and returns it. A separate peek register returns the oldest message without removing it. A status register reports full and empty. A configuration register holds the data-available interrupt enable and shows the data-available pending flag. When the queue is empty, a pop or a peek returns an all-ones marker that means "no valid message".

The interrupt output is a level. It is high while messages are waiting and the enable is set, so a host interrupt handler can drain the queue until the line drops. The queue depth is a parameter and defaults to eight.

Top module: `rx_mailbox`

## Requirements
- R1: A read at any byte offset 0x80 through 0x8F returns the oldest stored message and removes it, so successive pops return messages in arrival order.
- R2: A pop-window read while the queue is empty returns 0xFFFFFFFF and leaves the queue unchanged.
- R3: A read at offset 0x90 returns the oldest message without removing it, and returns 0xFFFFFFFF when the queue is empty.
- R4: A read at offset 0x98 returns bit 31 = 1 when the queue holds DEPTH messages and bit 30 = 1 when it holds none. All other bits are 0.
- R5: A write at offset 0x9C changes only the interrupt enable, taken from write-data bit 0. A read at 0x9C returns the enable in bit 0, and all other bits are 0 apart from bit 4.
- R6: Bit 4 of the offset-0x9C read value is 1 exactly when the queue is not empty.
- R7: `irq` is high exactly when the queue is not empty and the interrupt enable is 1.
- R8: After reset the queue is empty, the enable is 0, `irq` is low and a peek returns 0xFFFFFFFF.
- R9: Offset 0x94 reads as zero and ignores writes. Every offset not listed above also reads as zero, and writes to it have no effect.
- R10: `push_ready` is low while the queue is full. A message offered while the queue is full is dropped, and the queue never holds more than DEPTH messages.
- R11: A push and a pop in the same cycle leave the number of stored messages unchanged and keep arrival order. On an empty queue, the pop returns 0xFFFFFFFF and the pushed message is kept.
- R12: `bus_rdata` takes the read value at the clock edge that samples the read strobe, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_valid | input | 1 | Producer offers a message |
| push_data | input | 32 | Offered message |
| push_ready | output | 1 | Queue has room; an offered message is taken at the edge |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Data-available interrupt level |

## Verification
A read strobe and a push both act at one clock edge. Read data, the removal of a popped message, status, the pending flag and `irq` are all visible right after that same edge, with no further latency. Every operation is therefore driven at a falling edge and its results are sampled one nanosecond after the following rising edge. After a reset release, the internal two-flop synchronizer adds two cycles, and the bench waits them out before it accesses the block. The rule that read data is held is checked by sampling `bus_rdata` again after several idle cycles.

// File: rtl/rx_mailbox_pkg.sv
package rx_mailbox_pkg;

  localparam int unsigned MBX_DATA_W = 32;
  localparam logic [MBX_DATA_W-1:0] MBX_NO_MSG = 32'hFFFF_FFFF;

  // bit positions the host software decodes
  localparam int unsigned ST_FULL_BIT  = 31;
  localparam int unsigned ST_EMPTY_BIT = 30;
  localparam int unsigned CF_EN_BIT    = 0;
  localparam int unsigned CF_PEND_BIT  = 4;

  typedef enum logic [2:0] {
    WIN_POP,
    WIN_PEEK,
    WIN_SENDER,
    WIN_STATUS,
    WIN_CONFIG,
    WIN_NONE
  } win_reg_e;

  function automatic win_reg_e decode_offset(input logic [7:0] off);
    win_reg_e r;
    if (off[7:4] == 4'h8)  r = WIN_POP;
    else if (off == 8'h90) r = WIN_PEEK;
    else if (off == 8'h94) r = WIN_SENDER;
    else if (off == 8'h98) r = WIN_STATUS;
    else if (off == 8'h9C) r = WIN_CONFIG;
    else                   r = WIN_NONE;
    return r;
  endfunction

endpackage

// File: rtl/rx_mailbox_store.sv
module rx_mailbox_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 32,
  parameter logic [W-1:0] FILL = '1,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [W-1:0]     push_data,
  input  logic             pop_en,
  output logic [W-1:0]     head_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [DEPTH-1:0][W-1:0] slots;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push_en) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (pop_en)  rd_ptr_d = ptr_inc(rd_ptr_q);
    case ({push_en, pop_en})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (push_en || pop_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] slot_q, slot_d;
    logic         slot_we;
    logic         hit_wr, hit_rd;

    assign hit_wr = push_en && (wr_ptr_q == PTR_W'(i));
    assign hit_rd = pop_en  && (rd_ptr_q == PTR_W'(i));

    always_comb begin
      slot_we = hit_wr || hit_rd;
      slot_d  = slot_q;
      if (hit_rd) slot_d = FILL;       // a popped slot returns to the marker
      if (hit_wr) slot_d = push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= FILL;
      else if (slot_we) slot_q <= slot_d;
    end

    assign slots[i] = slot_q;
  end

  assign head_data = slots[rd_ptr_q];
  assign count     = count_q;
  assign full      = (count_q == CNT_W'(DEPTH));
  assign empty     = (count_q == '0);

endmodule

// File: rtl/rx_mailbox_regs.sv
module rx_mailbox_regs
  import rx_mailbox_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_sel,
  input  logic                  acc_wr,
  input  logic [7:0]            acc_off,
  input  logic [MBX_DATA_W-1:0] acc_wdata,
  input  logic [MBX_DATA_W-1:0] head_data,
  input  logic                  q_full,
  input  logic                  q_empty,
  output logic                  pop_en,
  output logic                  int_en,
  output logic [MBX_DATA_W-1:0] rdata
);

  win_reg_e              which;
  logic                  rd_stb, wr_stb;
  logic                  en_q, en_d, en_we;
  logic [MBX_DATA_W-1:0] rdata_q, rdata_d;
  logic                  unused_wdata_bits;

  assign which  = decode_offset(acc_off);
  assign rd_stb = acc_sel && !acc_wr;
  assign wr_stb = acc_sel &&  acc_wr;

  assign unused_wdata_bits = ^acc_wdata[MBX_DATA_W-1:1];

  // enable: only bit 0 of a configuration write is kept
  always_comb begin
    en_we = wr_stb && (which == WIN_CONFIG);
    en_d  = acc_wdata[CF_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_we) en_q <= en_d;
  end

  assign pop_en = rd_stb && (which == WIN_POP) && !q_empty;

  always_comb begin
    rdata_d = '0;
    case (which)
      WIN_POP, WIN_PEEK: rdata_d = q_empty ? MBX_NO_MSG : head_data;
      WIN_STATUS: begin
        rdata_d[ST_FULL_BIT]  = q_full;
        rdata_d[ST_EMPTY_BIT] = q_empty;
      end
      WIN_CONFIG: begin
        rdata_d[CF_EN_BIT]   = en_q;
        rdata_d[CF_PEND_BIT] = !q_empty;
      end
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_stb) rdata_q <= rdata_d;
  end

  assign int_en = en_q;
  assign rdata  = rdata_q;

endmodule

// File: rtl/rx_mailbox.sv
module rx_mailbox
  import rx_mailbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_valid,
  input  logic [MBX_DATA_W-1:0] push_data,
  output logic                  push_ready,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_addr,
  input  logic [MBX_DATA_W-1:0] bus_wdata,
  output logic [MBX_DATA_W-1:0] bus_rdata,
  output logic                  irq
);

  logic                  rst_meta_q, rst_sync_q;
  logic                  push_fire, pop_fire;
  logic                  q_full, q_empty;
  logic [CNT_W-1:0]      q_count;
  logic [MBX_DATA_W-1:0] q_head;
  logic                  int_en;

  // assert asynchronously, release on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign push_ready = !q_full;
  assign push_fire  = push_valid && !q_full;

  rx_mailbox_store #(
    .DEPTH (DEPTH),
    .W     (MBX_DATA_W),
    .FILL  (MBX_NO_MSG)
  ) store_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .push_en   (push_fire),
    .push_data (push_data),
    .pop_en    (pop_fire),
    .head_data (q_head),
    .count     (q_count),
    .full      (q_full),
    .empty     (q_empty)
  );

  rx_mailbox_regs regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .acc_sel   (bus_sel),
    .acc_wr    (bus_wr),
    .acc_off   (bus_addr),
    .acc_wdata (bus_wdata),
    .head_data (q_head),
    .q_full    (q_full),
    .q_empty   (q_empty),
    .pop_en    (pop_fire),
    .int_en    (int_en),
    .rdata     (bus_rdata)
  );

  assign irq = int_en && !q_empty;

endmodule

// File: rtl/rx_mailbox_chk.sv
module rx_mailbox_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             push_fire,
  input logic             pop_fire,
  input logic [CNT_W-1:0] count,
  input logic             q_full,
  input logic             q_empty,
  input logic             irq
);

  logic pop_req;
  assign pop_req = bus_sel && !bus_wr && (bus_addr[7:4] == 4'h8);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_empty_pop_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && q_empty && !push_fire) |=> (count == $past(count)));

  assert_pop_removes_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !push_fire) |=> (count == CNT_W'($past(count) - 1'b1)));

  assert_push_pop_same_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && push_fire) |=> (count == $past(count)));

  assert_irq_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count != '0));

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

endmodule

bind rx_mailbox rx_mailbox_chk #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_q),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .push_fire (push_fire),
  .pop_fire  (pop_fire),
  .count     (q_count),
  .q_full    (q_full),
  .q_empty   (q_empty),
  .irq       (irq)
);

// File: tb/rx_mailbox_tb_top.sv
module rx_mailbox_tb_top;

  localparam int unsigned DEPTH = 8;
  localparam logic [31:0] NOMSG = 32'hFFFF_FFFF;

  localparam logic [1:0] OP_RD = 2'd0;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_PU = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;     // write or push data
    logic [31:0] exp_rd;
    logic        chk_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{OP_RD, 8'h98, 32'h0,        32'h4000_0000, 1'b1, 1'b0, 4'd4 },  // R4 empty
    '{OP_RD, 8'h9C, 32'h0,        32'h0,         1'b1, 1'b0, 4'd8 },  // R8 config clear
    '{OP_RD, 8'h90, 32'h0,        NOMSG,         1'b1, 1'b0, 4'd3 },  // R3 empty peek
    '{OP_RD, 8'h80, 32'h0,        NOMSG,         1'b1, 1'b0, 4'd2 },  // R2 empty pop
    '{OP_PU, 8'h00, 32'h1111_1111, 32'h0,        1'b0, 1'b0, 4'd7 },  // R7 enable off
    '{OP_PU, 8'h00, 32'h2222_2222, 32'h0,        1'b0, 1'b0, 4'd7 },
    '{OP_RD, 8'h90, 32'h0,        32'h1111_1111, 1'b1, 1'b0, 4'd3 },  // R3 peek head
    '{OP_RD, 8'h98, 32'h0,        32'h0,         1'b1, 1'b0, 4'd4 },  // R4 neither
    '{OP_RD, 8'h9C, 32'h0,        32'h10,        1'b1, 1'b0, 4'd6 },  // R6 pending
    '{OP_WR, 8'h9C, 32'hFFFF_FFFF, 32'h0,        1'b0, 1'b1, 4'd7 },  // R7 irq rises
    '{OP_RD, 8'h9C, 32'h0,        32'h11,        1'b1, 1'b1, 4'd5 },  // R5 only bit0
    '{OP_RD, 8'h84, 32'h0,        32'h1111_1111, 1'b1, 1'b1, 4'd1 },  // R1 oldest
    '{OP_RD, 8'h8C, 32'h0,        32'h2222_2222, 1'b1, 1'b0, 4'd1 },  // R1 next, R7 drops
    '{OP_RD, 8'h98, 32'h0,        32'h4000_0000, 1'b1, 1'b0, 4'd4 },  // R4
    '{OP_RD, 8'h94, 32'h0,        32'h0,         1'b1, 1'b0, 4'd9 },  // R9 sender
    '{OP_WR, 8'h94, 32'h5,        32'h0,         1'b0, 1'b0, 4'd9 },
    '{OP_RD, 8'h94, 32'h0,        32'h0,         1'b1, 1'b0, 4'd9 },  // R9 write ignored
    '{OP_RD, 8'h50, 32'h0,        32'h0,         1'b1, 1'b0, 4'd9 },  // R9 unsupported
    '{OP_WR, 8'h9C, 32'hFFFF_FFFE, 32'h0,        1'b0, 1'b0, 4'd5 },  // R5 enable off
    '{OP_RD, 8'h9C, 32'h0,        32'h0,         1'b1, 1'b0, 4'd5 }
  };

  logic        clk, rst_n;
  logic        push_valid, push_ready;
  logic [31:0] push_data;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  rx_mailbox #(.DEPTH(DEPTH)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_data  (push_data),
    .push_ready (push_ready),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // drive at falling edge, act at rising edge, sample 1 ns later
  task automatic cycle(input logic rd, input logic wr, input logic [7:0] a,
                       input logic [31:0] wd, input logic pv, input logic [31:0] pd);
    @(negedge clk);
    bus_sel    = rd | wr;
    bus_wr     = wr;
    bus_addr   = a;
    bus_wdata  = wd;
    push_valid = pv;
    push_data  = pd;
    @(posedge clk);
    #1;
    bus_sel    = 1'b0;
    bus_wr     = 1'b0;
    push_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    push_valid = 0; push_data = 0; rst_n = 0;
    do_reset();

    // R8: reset state
    check("R8 irq", {31'b0, irq}, 32'h0);
    check("R8 push_ready", {31'b0, push_ready}, 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      cycle(v.op == OP_RD, v.op == OP_WR, v.addr, v.data, v.op == OP_PU, v.data);
      if (v.chk_rd) check($sformatf("R%0d vec%0d rdata", v.req, i), bus_rdata, v.exp_rd);
      check($sformatf("R7 vec%0d irq", i), {31'b0, irq}, {31'b0, v.exp_irq});
    end

    // R12: read data holds across idle cycles
    cycle(1, 0, 8'h98, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R12 hold", bus_rdata, 32'h4000_0000);

    // R10: fill, overflow, drain
    cycle(0, 1, 8'h9C, 32'h1, 0, 0);
    for (int k = 0; k < DEPTH; k++) cycle(0, 0, 8'h00, 0, 1, 32'hA000_0000 + k);
    check("R10 push_ready full", {31'b0, push_ready}, 32'h0);
    cycle(1, 0, 8'h98, 0, 0, 0);
    check("R4 full status", bus_rdata, 32'h8000_0000);
    cycle(0, 0, 8'h00, 0, 1, 32'hDEAD_BEEF);
    check("R7 irq full", {31'b0, irq}, 32'h1);
    for (int k = 0; k < DEPTH; k++) begin
      cycle(1, 0, 8'h80 + 8'(4 * (k % 4)), 0, 0, 0);
      check($sformatf("R1 drain %0d", k), bus_rdata, 32'hA000_0000 + k);
    end
    cycle(1, 0, 8'h80, 0, 0, 0);
    check("R10 dropped push", bus_rdata, NOMSG);
    check("R7 irq empty", {31'b0, irq}, 32'h0);

    // R11: push and pop together
    cycle(1, 0, 8'h80, 0, 1, 32'h0000_00C1);
    check("R11 empty pop with push", bus_rdata, NOMSG);
    cycle(1, 0, 8'h80, 0, 1, 32'h0000_00C2);
    check("R11 pop with push", bus_rdata, 32'h0000_00C1);
    cycle(1, 0, 8'h90, 0, 0, 0);
    check("R11 head after", bus_rdata, 32'h0000_00C2);
    cycle(1, 0, 8'h88, 0, 0, 0);
    check("R11 last", bus_rdata, 32'h0000_00C2);
    cycle(1, 0, 8'h98, 0, 0, 0);
    check("R11 empty after", bus_rdata, 32'h4000_0000);

    // R8: reset with data and enable set
    cycle(0, 0, 8'h00, 0, 1, 32'h0000_0077);
    check("R7 irq before reset", {31'b0, irq}, 32'h1);
    do_reset();
    check("R8 irq after reset", {31'b0, irq}, 32'h0);
    cycle(1, 0, 8'h90, 0, 0, 0);
    check("R8 peek after reset", bus_rdata, NOMSG);
    cycle(1, 0, 8'h9C, 0, 0, 0);
    check("R8 config after reset", bus_rdata, 32'h0);

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule